// File: doc/BRIEF.md
# Queued-Sample Pulse-Width Modulator

This block is a single-channel pulse-width modulator with a small register interface. Software sets a period and a clock divider, then feeds duty-cycle values into a short queue. The block takes one value from the queue at a time and uses it for a programmable number of output periods before it takes the next one. Software can therefore stream duty values ahead of the hardware and does not have to meet a write deadline on every period.

A free-running prescaler divides the block clock by a 12-bit ratio. Each divided tick advances a period counter. The output goes high when the period starts and drops when the counter reaches the active duty value. The output can also be inverted or held low. When the queue runs dry, the last value taken stays in use, so the waveform continues without a gap. Sticky status flags report counter wrap, duty match, a write into a full queue and a low queue level. A self-clearing soft reset returns the block to its idle state.

Registers sit on a plain 32-bit bus. A write completes in the cycle it is presented. Read data appears on `bus_rdata` one clock after `bus_rd` is sampled high.

Top module: `pwm_fifo_ctrl`

## Requirements
- R1: After reset, the register at 0x00 reads 0, the register at 0x0C reads 0 and the register at 0x10 reads 0. From the second cycle after reset onward, the register at 0x04 reads 0x8: queue level 0 with the low-level flag set.
- R2: One output period lasts (value at 0x10) + 2 counter ticks. In normal mode the output is high for the first N ticks of a period, where N is the active duty value.
- R3: A period value of 0xFFFF gives the same 65536-tick period as 0xFFFE.
- R4: Bits 15:4 at 0x00 hold the divide ratio minus one. A counter tick occurs every (field + 1) clocks while the block is running.
- R5: Bits 19:18 at 0x00 choose the output mode. 0 is normal, 1 is inverted, and 2 or 3 holds the output low.
- R6: Bits 2:1 at 0x00 set how many periods each duty value is used before the next one is taken: 0 once, 1 twice, 2 four times, 3 eight times.
- R7: A write to 0x0C adds a value to a 4-entry queue. Status bits 2:0 give the number of queued entries. The first entry is taken when the block starts. After that, entries are taken only at a period wrap. With the queue empty, the active value is kept.
- R8: A write to 0x0C while 4 entries are queued is dropped and sets status bit 6.
- R9: Writing 1 to bit 3 at 0x00 flushes the queue and clears every register, flag and counter. Bit 3 then reads 1 for 8 cycles, and register writes made during that time have no effect. After that the bit clears itself.
- R10: Status bit 4 is set at each counter wrap. Status bit 5 is set on a tick where the count equals the active value. Status flags are sticky and are cleared by writing 1 to them at 0x04. A new set event wins over a clear in the same cycle.
- R11: Status bit 3 is set while the queue level is at or below the watermark in bits 27:26 of 0x00.
- R12: Bit 0 at 0x00 enables the block. When it is 0, the output is low and the counters are cleared. With the block enabled, a clock-source field (bits 17:16) of 0 freezes the counters and holds the output. The register at 0x0C reads the active value while enabled and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 5 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered one cycle after the read strobe |
| pwm_out | output | 1 | Registered modulated output |

## Verification
The bench goes after five corner cases.
- Queue underrun: a design that returned stale queue data or zero instead of repeating the last value would make the output collapse or jump.
- Write into a full queue: if it overwrote the oldest entry, the level readback and the order of later pulses would be wrong.
- The 0xFFFF period: a design that wrapped its count limit past 16 bits would roll over on every tick instead of once in 65536 ticks.
- Writes during soft reset: a design that still accepted them would show a non-zero period afterward.
- Clock-source freeze: a stopped clock must hold the output level, whereas disabling must force it low. A design that confused the two would fail the held-level check.

// File: rtl/pwmq_pkg.sv
package pwmq_pkg;
  localparam int ADDR_CTRL = 'h00;
  localparam int ADDR_STAT = 'h04;
  localparam int ADDR_SAMP = 'h0C;
  localparam int ADDR_PER  = 'h10;

  // control field positions (decoded by software)
  localparam int C_EN      = 0;
  localparam int C_REP_LO  = 1;
  localparam int C_SWR     = 3;
  localparam int C_DIV_LO  = 4;
  localparam int C_SRC_LO  = 16;
  localparam int C_MODE_LO = 18;
  localparam int C_WM_LO   = 26;

  // status flag positions
  localparam int S_FE  = 3;
  localparam int S_ROV = 4;
  localparam int S_CMP = 5;
  localparam int S_FWE = 6;

  typedef enum logic [1:0] {
    OUT_NORMAL  = 2'd0,
    OUT_INVERT  = 2'd1,
    OUT_OFF     = 2'd2,
    OUT_OFF_ALT = 2'd3
  } out_mode_e;

  typedef struct packed {
    logic fwe;
    logic cmp;
    logic rov;
    logic fe;
  } flags_t;
endpackage

// File: rtl/pwmq_prescaler.sv
module pwmq_prescaler #(
  parameter int DIV_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             run,
  input  logic [DIV_W-1:0] div_m1,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;

  assign tick = run && (cnt == div_m1);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt <= '0;
    end else if (run) begin
      if (tick) cnt <= '0;
      else      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/pwmq_sample_fifo.sv
module pwmq_sample_fifo #(
  parameter int DW    = 16,
  parameter int DEPTH = 4,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int LW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          flush,
  input  logic          push,
  input  logic [DW-1:0] wdata,
  input  logic          pop,
  output logic [DW-1:0] head,
  output logic [LW-1:0] level,
  output logic          full,
  output logic          empty
);
  localparam logic [LW-1:0] LVL_MAX = LW'(DEPTH);
  localparam logic [AW-1:0] PTR_MAX = AW'(DEPTH - 1);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic          push_ok, pop_ok;

  assign full    = (level == LVL_MAX);
  assign empty   = (level == '0);
  assign push_ok = push && !full && !flush;
  assign pop_ok  = pop && !empty && !flush;
  assign head    = mem[rd_ptr];

  // storage carries no reset so it maps onto RAM
  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      level  <= '0;
    end else begin
      if (push_ok) wr_ptr <= (wr_ptr == PTR_MAX) ? '0 : wr_ptr + 1'b1;
      if (pop_ok)  rd_ptr <= (rd_ptr == PTR_MAX) ? '0 : rd_ptr + 1'b1;
      case ({push_ok, pop_ok})
        2'b10:   level <= level + 1'b1;
        2'b01:   level <= level - 1'b1;
        default: level <= level;
      endcase
    end
  end
endmodule

// File: rtl/pwmq_period_core.sv
module pwmq_period_core
  import pwmq_pkg::*;
#(
  parameter int SW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          hard_clr,
  input  logic          en,
  input  logic          run,
  input  logic          tick,
  input  logic [SW-1:0] per_val,
  input  logic [1:0]    rep_sel,
  input  out_mode_e     mode,
  input  logic          fifo_empty,
  input  logic [SW-1:0] fifo_head,
  output logic          fifo_pop,
  output logic [SW-1:0] act_sample,
  output logic          rov_evt,
  output logic          cmp_evt,
  output logic          pwm_q
);
  localparam logic [SW-1:0] PER_CLAMP = {{(SW-1){1'b1}}, 1'b0};

  logic [SW-1:0] cnt, eff_per, top;
  logic [2:0]    rep_cnt;
  logic [3:0]    reps;
  logic          primed, prime, step, wrap, rep_last, below;

  assign eff_per  = (per_val > PER_CLAMP) ? PER_CLAMP : per_val;
  assign top      = eff_per + 1'b1;
  assign reps     = 4'd1 << rep_sel;
  assign rep_last = ({1'b0, rep_cnt} == (reps - 4'd1));
  assign prime    = run && !primed;
  assign step     = run && primed && tick;
  assign wrap     = (cnt == top);
  assign below    = (cnt < act_sample);

  assign fifo_pop = !hard_clr && !fifo_empty &&
                    (prime || (step && wrap && rep_last));
  assign rov_evt  = !hard_clr && step && wrap;
  assign cmp_evt  = !hard_clr && step && (cnt == act_sample);

  always_ff @(posedge clk) begin
    if (rst || hard_clr) begin
      cnt        <= '0;
      rep_cnt    <= '0;
      primed     <= 1'b0;
      act_sample <= '0;
    end else begin
      if (!en) begin
        cnt     <= '0;
        rep_cnt <= '0;
        primed  <= 1'b0;
      end else if (prime) begin
        primed <= 1'b1;
      end else if (step) begin
        if (wrap) begin
          cnt     <= '0;
          rep_cnt <= rep_last ? 3'd0 : rep_cnt + 3'd1;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
      if (fifo_pop) act_sample <= fifo_head;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || hard_clr) begin
      pwm_q <= 1'b0;
    end else if (en && primed) begin
      case (mode)
        OUT_NORMAL: pwm_q <= below;
        OUT_INVERT: pwm_q <= !below;
        default:    pwm_q <= 1'b0;
      endcase
    end else begin
      pwm_q <= 1'b0;
    end
  end
endmodule

// File: rtl/pwm_fifo_ctrl.sv
module pwm_fifo_ctrl
  import pwmq_pkg::*;
#(
  parameter int ADDR_W     = 5,
  parameter int SAMPLE_W   = 16,
  parameter int DIV_W      = 12,
  parameter int FIFO_DEPTH = 4,
  parameter int RST_CYCLES = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              pwm_out
);
  localparam int LVL_W = $clog2(FIFO_DEPTH + 1);
  localparam int SWR_W = $clog2(RST_CYCLES + 1);

  // control state
  logic              ctrl_en;
  logic [1:0]        ctrl_rep;
  logic [DIV_W-1:0]  ctrl_div;
  logic [1:0]        ctrl_src;
  out_mode_e         ctrl_mode;
  logic [1:0]        ctrl_wm;
  logic [SAMPLE_W-1:0] per_reg;
  logic [SWR_W-1:0]  swr_cnt;
  flags_t            flags;

  logic swr_active, swr_start, acc;
  logic wr_ctrl, wr_stat, wr_samp, wr_per;
  logic run, tick, fifo_pop, fifo_full, fifo_empty, rov_evt, cmp_evt;
  logic [LVL_W-1:0]    fifo_level;
  logic [SAMPLE_W-1:0] fifo_head, act_sample;
  flags_t flag_set, flag_clr;

  assign swr_active = (swr_cnt != '0);
  assign acc        = bus_wr && !swr_active;
  assign wr_ctrl    = acc && (bus_addr == ADDR_W'(ADDR_CTRL));
  assign wr_stat    = acc && (bus_addr == ADDR_W'(ADDR_STAT));
  assign wr_samp    = acc && (bus_addr == ADDR_W'(ADDR_SAMP));
  assign wr_per     = acc && (bus_addr == ADDR_W'(ADDR_PER));
  assign swr_start  = wr_ctrl && bus_wdata[C_SWR];
  assign run        = ctrl_en && (ctrl_src != 2'd0);

  always_ff @(posedge clk) begin
    if (rst || swr_start) begin
      ctrl_en   <= 1'b0;
      ctrl_rep  <= '0;
      ctrl_div  <= '0;
      ctrl_src  <= '0;
      ctrl_mode <= OUT_NORMAL;
      ctrl_wm   <= '0;
      per_reg   <= '0;
    end else begin
      if (wr_ctrl) begin
        ctrl_en   <= bus_wdata[C_EN];
        ctrl_rep  <= bus_wdata[C_REP_LO +: 2];
        ctrl_div  <= bus_wdata[C_DIV_LO +: DIV_W];
        ctrl_src  <= bus_wdata[C_SRC_LO +: 2];
        ctrl_mode <= out_mode_e'(bus_wdata[C_MODE_LO +: 2]);
        ctrl_wm   <= bus_wdata[C_WM_LO +: 2];
      end
      if (wr_per) per_reg <= bus_wdata[SAMPLE_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)            swr_cnt <= '0;
    else if (swr_start) swr_cnt <= SWR_W'(RST_CYCLES);
    else if (swr_active) swr_cnt <= swr_cnt - 1'b1;
  end

  // sticky flags: set wins over write-one-to-clear
  always_comb begin
    flag_set.fwe = wr_samp && fifo_full;
    flag_set.cmp = cmp_evt;
    flag_set.rov = rov_evt;
    flag_set.fe  = !swr_active && (fifo_level <= LVL_W'(ctrl_wm));
    flag_clr     = wr_stat ? flags_t'(bus_wdata[S_FWE:S_FE]) : '0;
  end

  always_ff @(posedge clk) begin
    if (rst || swr_start || swr_active) flags <= '0;
    else flags <= (flags & ~flag_clr) | flag_set;
  end

  pwmq_sample_fifo #(.DW(SAMPLE_W), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk   (clk),
    .rst   (rst),
    .flush (swr_start),
    .push  (wr_samp),
    .wdata (bus_wdata[SAMPLE_W-1:0]),
    .pop   (fifo_pop),
    .head  (fifo_head),
    .level (fifo_level),
    .full  (fifo_full),
    .empty (fifo_empty)
  );

  pwmq_prescaler #(.DIV_W(DIV_W)) u_presc (
    .clk    (clk),
    .rst    (rst),
    .clr    (swr_start || !ctrl_en),
    .run    (run),
    .div_m1 (ctrl_div),
    .tick   (tick)
  );

  pwmq_period_core #(.SW(SAMPLE_W)) u_core (
    .clk        (clk),
    .rst        (rst),
    .hard_clr   (swr_start),
    .en         (ctrl_en),
    .run        (run),
    .tick       (tick),
    .per_val    (per_reg),
    .rep_sel    (ctrl_rep),
    .mode       (ctrl_mode),
    .fifo_empty (fifo_empty),
    .fifo_head  (fifo_head),
    .fifo_pop   (fifo_pop),
    .act_sample (act_sample),
    .rov_evt    (rov_evt),
    .cmp_evt    (cmp_evt),
    .pwm_q      (pwm_out)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else if (bus_rd) begin
      bus_rdata <= '0;
      case (bus_addr)
        ADDR_W'(ADDR_CTRL): begin
          bus_rdata[C_EN]             <= ctrl_en;
          bus_rdata[C_REP_LO +: 2]    <= ctrl_rep;
          bus_rdata[C_SWR]            <= swr_active;
          bus_rdata[C_DIV_LO +: DIV_W] <= ctrl_div;
          bus_rdata[C_SRC_LO +: 2]    <= ctrl_src;
          bus_rdata[C_MODE_LO +: 2]   <= ctrl_mode;
          bus_rdata[C_WM_LO +: 2]     <= ctrl_wm;
        end
        ADDR_W'(ADDR_STAT): begin
          bus_rdata[LVL_W-1:0]   <= fifo_level;
          bus_rdata[S_FWE:S_FE]  <= flags;
        end
        ADDR_W'(ADDR_SAMP): bus_rdata[SAMPLE_W-1:0] <= ctrl_en ? act_sample : '0;
        ADDR_W'(ADDR_PER):  bus_rdata[SAMPLE_W-1:0] <= per_reg;
        default: bus_rdata <= '0;
      endcase
    end
  end
endmodule

// File: rtl/pwmq_checker.sv
module pwmq_checker #(
  parameter int ADDR_W = 5,
  parameter int LVL_W  = 3,
  parameter int DEPTH  = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              pwm_out,
  input logic [LVL_W-1:0]  fifo_level,
  input logic              swr_start,
  input logic              swr_active,
  input logic              ctrl_en,
  input logic [1:0]        ctrl_mode,
  input logic              flag_fwe
);
  localparam logic [LVL_W-1:0]  LMAX = LVL_W'(DEPTH);
  localparam logic [ADDR_W-1:0] SAMP = ADDR_W'('h0C);

  AST_LEVEL_BOUND: assert property (@(posedge clk) disable iff (rst)
    fifo_level <= LMAX); // R7

  AST_LEVEL_STEP: assert property (@(posedge clk) disable iff (rst)
    !swr_start |=> (fifo_level == $past(fifo_level)) ||
                   (fifo_level == $past(fifo_level) + 1'b1) ||
                   (fifo_level + 1'b1 == $past(fifo_level))); // R7

  AST_FULL_REJECT: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == SAMP && fifo_level == LMAX && !swr_active)
      |=> flag_fwe && fifo_level >= LMAX - 1'b1); // R8

  AST_SWR_CLEARS: assert property (@(posedge clk) disable iff (rst)
    swr_start |=> !ctrl_en && fifo_level == '0 && swr_active && !pwm_out); // R9

  AST_SWR_IGNORES_PUSH: assert property (@(posedge clk) disable iff (rst)
    (swr_active && bus_wr && bus_addr == SAMP) |=> fifo_level == '0); // R9

  AST_OFF_LOW: assert property (@(posedge clk) disable iff (rst)
    ctrl_mode[1] |=> !pwm_out); // R5

  AST_DISABLED_LOW: assert property (@(posedge clk) disable iff (rst)
    !ctrl_en |=> !pwm_out); // R12
endmodule

bind pwm_fifo_ctrl pwmq_checker u_chk (
  .clk        (clk),
  .rst        (rst),
  .bus_wr     (bus_wr),
  .bus_addr   (bus_addr),
  .pwm_out    (pwm_out),
  .fifo_level (fifo_level),
  .swr_start  (swr_start),
  .swr_active (swr_active),
  .ctrl_en    (ctrl_en),
  .ctrl_mode  (ctrl_mode),
  .flag_fwe   (flags.fwe)
);

// File: tb/pwm_fifo_ctrl_bench.sv
module pwm_fifo_ctrl_bench;
  localparam int RSTC = 8;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        pwm_out;

  int checks = 0, errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  pwm_fifo_ctrl u_pwm_fifo_ctrl (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pwm_out(pwm_out)
  );

  // ---------------- behavioural reference model ----------------
  int m_en, m_rep, m_div, m_src, m_mode, m_wm, m_per, m_swr;
  int m_pre, m_cnt, m_repc, m_primed, m_act, m_out;
  bit m_fwe, m_cmp, m_rov, m_fe;
  int q[$];
  logic [31:0] m_rdata;

  function automatic logic [31:0] model_read(int a);
    logic [31:0] v = 0;
    case (a)
      'h00: v = m_en | (m_rep << 1) | ((m_swr > 0) << 3) | (m_div << 4) |
                (m_src << 16) | (m_mode << 18) | (m_wm << 26);
      'h04: v = q.size() | (m_fe << 3) | (m_rov << 4) | (m_cmp << 5) | (m_fwe << 6);
      'h0C: v = m_en ? m_act : 0;
      'h10: v = m_per;
      default: v = 0;
    endcase
    return v;
  endfunction

  task automatic model_step();
    int a = bus_addr;
    bit acc = bus_wr && (m_swr == 0);
    int lvl = q.size();
    bit run = (m_en != 0) && (m_src != 0);
    bit tick = run && (m_pre == m_div);
    int eff = (m_per > 'hFFFE) ? 'hFFFE : m_per;
    bit pop = 0, rov = 0, cmp = 0;
    if (bus_rd) m_rdata = model_read(a);
    if (acc && a == 'h00 && bus_wdata[3]) begin
      m_en = 0; m_rep = 0; m_div = 0; m_src = 0; m_mode = 0; m_wm = 0; m_per = 0;
      m_swr = RSTC; m_pre = 0; m_cnt = 0; m_repc = 0; m_primed = 0; m_act = 0;
      m_out = 0; m_fwe = 0; m_cmp = 0; m_rov = 0; m_fe = 0; q.delete();
      return;
    end
    if (m_en != 0 && m_primed != 0)
      m_out = (m_mode == 0) ? int'(m_cnt < m_act) :
              (m_mode == 1) ? int'(!(m_cnt < m_act)) : 0;
    else m_out = 0;
    if (m_en == 0) m_pre = 0;
    else if (run) m_pre = tick ? 0 : m_pre + 1;
    if (m_en == 0) begin
      m_cnt = 0; m_repc = 0; m_primed = 0;
    end else if (run && m_primed == 0) begin
      m_primed = 1; pop = 1;
    end else if (run && tick) begin
      cmp = (m_cnt == m_act);
      if (m_cnt == eff + 1) begin
        rov = 1; m_cnt = 0;
        if (m_repc == (1 << m_rep) - 1) begin m_repc = 0; pop = 1; end
        else m_repc++;
      end else m_cnt++;
    end
    if (m_swr > 0) begin
      m_fwe = 0; m_cmp = 0; m_rov = 0; m_fe = 0; m_swr--;
    end else begin
      if (acc && a == 'h04) begin
        if (bus_wdata[3]) m_fe = 0;
        if (bus_wdata[4]) m_rov = 0;
        if (bus_wdata[5]) m_cmp = 0;
        if (bus_wdata[6]) m_fwe = 0;
      end
      if (lvl <= m_wm) m_fe = 1;
      if (rov) m_rov = 1;
      if (cmp) m_cmp = 1;
      if (acc && a == 'h0C && lvl == 4) m_fwe = 1;
    end
    if (pop && q.size() > 0) m_act = q.pop_front();
    if (acc && a == 'h0C && lvl < 4) q.push_back(bus_wdata[15:0]);
    if (acc && a == 'h00) begin
      m_en = bus_wdata[0]; m_rep = bus_wdata[2:1]; m_div = bus_wdata[15:4];
      m_src = bus_wdata[17:16]; m_mode = bus_wdata[19:18]; m_wm = bus_wdata[27:26];
    end
    if (acc && a == 'h10) m_per = bus_wdata[15:0];
  endtask

  always @(posedge clk) begin
    if (rst) begin
      m_en = 0; m_rep = 0; m_div = 0; m_src = 0; m_mode = 0; m_wm = 0; m_per = 0;
      m_swr = 0; m_pre = 0; m_cnt = 0; m_repc = 0; m_primed = 0; m_act = 0;
      m_out = 0; m_fwe = 0; m_cmp = 0; m_rov = 0; m_fe = 0; m_rdata = 0;
      q.delete();
    end else model_step();
  end

  // output compared on every cycle, away from the active edge
  always @(negedge clk) begin
    if (!rst && !done) begin
      checks++;
      if (pwm_out !== m_out[0]) begin
        errors++;
        $display("FAIL R2/R5 output at %0t: actual %0b expected %0b", $time, pwm_out, m_out[0]);
      end
    end
  end

  // ---------------- helpers ----------------
  task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(int a, logic [31:0] d);
    @(negedge clk);
    bus_wr = 1; bus_addr = a[4:0]; bus_wdata = d;
    @(negedge clk);
    bus_wr = 0;
  endtask

  task automatic rd(int a, string tag, output logic [31:0] v);
    @(negedge clk);
    bus_rd = 1; bus_addr = a[4:0];
    @(negedge clk);
    bus_rd = 0;
    v = bus_rdata;
    chk(bus_rdata === m_rdata, tag, bus_rdata, m_rdata);
  endtask

  function automatic logic [31:0] ctl(int en, int rep, int div_m1, int src, int mode, int wm);
    return 32'(en | (rep << 1) | (div_m1 << 4) | (src << 16) | (mode << 18) | (wm << 26));
  endfunction

  task automatic count_high(int n, output int ones);
    ones = 0;
    repeat (n) begin @(negedge clk); ones += int'(pwm_out); end
  endtask

  // ---------------- stimulus ----------------
  initial begin
    logic [31:0] v;
    int ones;
    logic held;
    repeat (5) @(negedge clk);
    rst = 0;
    repeat (3) @(negedge clk);

    rd('h00, "R1 ctrl reset", v);   chk(v == 0, "R1 ctrl reset value", v, 0);
    rd('h04, "R1 status reset", v); chk(v == 32'h8, "R1 status reset value", v, 32'h8);
    rd('h0C, "R1 sample reset", v); chk(v == 0, "R1 sample reset value", v, 0);
    rd('h10, "R1 period reset", v); chk(v == 0, "R1 period reset value", v, 0);

    // R2: period 8 -> 10 ticks, duty 4, divide by 1
    wr('h10, 8);
    wr('h0C, 4);
    wr('h00, ctl(1, 0, 0, 1, 0, 0));
    repeat (40) @(negedge clk);
    count_high(100, ones); chk(ones == 40, "R2 high time normal", ones, 40);
    // R5 inverted
    wr('h00, ctl(1, 0, 0, 1, 1, 0));
    repeat (20) @(negedge clk);
    count_high(100, ones); chk(ones == 60, "R5 high time inverted", ones, 60);
    // R4 divide by 3: period 30 clocks, high 12
    wr('h00, ctl(1, 0, 2, 1, 0, 0));
    repeat (60) @(negedge clk);
    count_high(120, ones); chk(ones == 48, "R4 high time divided", ones, 48);
    rd('h0C, "R12 sample while enabled", v); chk(v == 4, "R7 last value kept", v, 4);

    // R6 repeat twice with a queue of three values
    wr('h00, 0);
    wr('h0C, 2); wr('h0C, 6); wr('h0C, 3);
    rd('h04, "R7 level three", v); chk(v[2:0] == 3, "R7 level field", v[2:0], 3);
    wr('h00, ctl(1, 1, 0, 1, 0, 0));
    repeat (30) @(negedge clk);
    rd('h04, "R6 level mid stream", v);
    repeat (170) @(negedge clk);
    rd('h0C, "R6 final sample", v); chk(v == 3, "R7 queue drained to last", v, 3);
    wr('h00, ctl(1, 3, 0, 1, 0, 0));
    wr('h0C, 9); wr('h0C, 1);
    repeat (120) @(negedge clk);
    rd('h0C, "R6 eight-fold repeat", v);

    // R8 overfill while disabled
    wr('h00, 0);
    for (int i = 0; i < 5; i++) wr('h0C, 5 + i);
    rd('h04, "R8 full status", v);
    chk((v & 32'h47) == 32'h44, "R8 full level and write error", v & 32'h47, 32'h44);

    // R10 clear flags
    wr('h04, 32'h78);
    rd('h04, "R10 flags cleared", v);
    chk((v & 32'h78) == 0, "R10 w1c", v & 32'h78, 0);

    // R11 watermark 3 while running; R10 events
    wr('h00, ctl(1, 0, 0, 1, 0, 3));
    repeat (25) @(negedge clk);
    rd('h04, "R11 R10 running status", v);
    chk(v[3] && v[4] && v[5], "R11 R10 fe rov cmp set", v & 32'h38, 32'h38);

    // R12 clock source zero freezes
    wr('h00, ctl(1, 0, 0, 0, 0, 3));
    @(negedge clk); held = pwm_out;
    count_high(20, ones);
    chk(ones == (held ? 20 : 0), "R12 frozen output held", ones, held ? 20 : 0);
    rd('h0C, "R12 sample frozen", v);

    // R5 forced off
    wr('h00, ctl(1, 0, 0, 1, 2, 0));
    repeat (5) @(negedge clk);
    count_high(20, ones); chk(ones == 0, "R5 off mode", ones, 0);

    wr('h00, 0);
    rd('h0C, "R12 sample disabled", v); chk(v == 0, "R12 sample reads 0 off", v, 0);

    // R9 software reset
    wr('h0C, 7); wr('h10, 20);
    wr('h00, ctl(1, 2, 5, 1, 1, 2) | 32'h8);
    rd('h00, "R9 busy bit", v); chk(v == 32'h8, "R9 busy reads 1", v, 32'h8);
    wr('h10, 'h55);
    wr('h0C, 3);
    repeat (12) @(negedge clk);
    rd('h00, "R9 self clear", v);  chk(v == 0, "R9 ctrl cleared", v, 0);
    rd('h10, "R9 period cleared", v); chk(v == 0, "R9 write ignored", v, 0);
    rd('h04, "R9 queue flushed", v); chk(v[2:0] == 0, "R9 level zero", v[2:0], 0);

    // R3 clamp of 0xFFFF
    wr('h10, 'hFFFF);
    wr('h0C, 3);
    wr('h00, ctl(1, 0, 0, 1, 0, 0));
    wr('h04, 32'h78);
    repeat (65380) @(negedge clk);
    rd('h04, "R3 before wrap", v); chk(v[4] == 0, "R3 no early wrap", v[4], 0);
    repeat (300) @(negedge clk);
    rd('h04, "R3 after wrap", v); chk(v[4] == 1, "R3 wrap after 65536 ticks", v[4], 1);
    rd('h10, "R3 period readback", v);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule